// File: doc/BRIEF.md
# Addressable LED Serial Encoder

The encoder turns a stream of colour bytes into the single-wire return-to-zero waveform that daisy-chained smart RGB LEDs expect. Each byte is accepted over a valid/ready handshake, held in a one-entry buffer, and shifted out most significant bit first. Every bit occupies a fixed period made of two equal half-periods. A '0' is a short high pulse. A '1' is high for one full half-period plus one extra tick. All edges fall on a tick that is divided down from the system clock.

A byte is offered with a `last_i` flag. When that byte has been sent, the line is held low for a programmable number of ticks so that the LEDs latch their new colours. The encoder does not look at colour order, so RGB, GRB and four-channel pixels are all just byte sequences to it. A per-byte `slow_i` flag selects a longer half-period.

Top module: `led_wave_enc`

## Requirements
- R1: In reset, and right after it, `line_o` is low, `ready_o` is high and `busy_o` is low.
- R2: A tick occurs once every TICK_DIV clocks. Line edges happen only in the cycle after a tick. Within a byte in normal mode, rising edges are 2*HALF_NORM ticks apart.
- R3: A '0' bit drives the line high for ZERO_HIGH ticks, then low for the rest of the bit period.
- R4: A '1' bit drives the line high for one half-period plus ONE_EXTRA ticks, then low for the rest of the bit period.
- R5: `slow_i` is captured with each byte. When it is 1, the half-period is HALF_SLOW ticks instead of HALF_NORM, for both the bit period and the '1' high time.
- R6: Bits are sent most significant first. Byte 0x80 produces a long first pulse followed by seven short ones.
- R7: Outside an active byte the line stays low, so no stray pulses appear between bytes or while idle.
- R8: A byte accepted before the current byte's last bit ends starts on the very next bit boundary, with no gap.
- R9: After a byte flagged `last_i`, the line stays low for `rst_len_i` ticks (0 is treated as 1) before the encoder returns to idle. `busy_o` stays high for that whole interval.
- R10: `ready_o` is high exactly when the one-entry buffer is empty. After a byte is accepted, `ready_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_i | input | 1 | Slow bit rate for the offered byte |
| rst_len_i | input | RL_W | Latch interval length in ticks |
| data_i | input | 8 | Colour byte |
| last_i | input | 1 | Offered byte ends the frame |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Buffer empty, byte can be accepted |
| line_o | output | 1 | Serial LED data line |
| busy_o | output | 1 | Byte pending, shifting, or latch interval running |

## Verification
The checker's properties make no demand on the inputs. The handshake, flags and interval length may change on any cycle, and the properties constrain only how the line and flags respond. The pulse-length bound assumes that `slow_i` is the only thing that lengthens a '1', so the stimulus changes TICK_DIV only at elaboration. The bench drives inputs on the falling clock edge and keeps `rst_len_i` stable from the last byte's acceptance until the latch interval ends. This matters because the interval length is sampled when the final bit completes, not when the byte is accepted.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } enc_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       last;
    logic       slow;
  } pend_t;
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == TOP) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == TOP);
endmodule

// File: rtl/led_byte_buf.sv
module led_byte_buf
  import led_enc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  pend_t ent_i,
  input  logic  pop_i,
  output logic  ready_o,
  output logic  full_o,
  output pend_t ent_o
);
  logic  full_q;
  pend_t ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      ent_q  <= '0;
    end else if (valid_i && !full_q) begin
      full_q <= 1'b1;
      ent_q  <= ent_i;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end
  end

  assign ready_o = !full_q;
  assign full_o  = full_q;
  assign ent_o   = ent_q;
endmodule

// File: rtl/led_bit_shaper.sv
module led_bit_shaper #(
  parameter int unsigned HALF_NORM = 5,
  parameter int unsigned HALF_SLOW = 6,
  parameter int unsigned ZERO_HIGH = 3,
  parameter int unsigned ONE_EXTRA = 1,
  parameter int unsigned TW        = 4
) (
  input  logic          active_i,
  input  logic          bit_i,
  input  logic          slow_i,
  input  logic [TW-1:0] tcnt_i,
  output logic          line_o,
  output logic          bit_end_o
);
  localparam logic [TW-1:0] HI_ZERO  = TW'(ZERO_HIGH);
  localparam logic [TW-1:0] HI_ONE_N = TW'(HALF_NORM + ONE_EXTRA);
  localparam logic [TW-1:0] HI_ONE_S = TW'(HALF_SLOW + ONE_EXTRA);
  localparam logic [TW-1:0] LAST_N   = TW'(2 * HALF_NORM - 1);
  localparam logic [TW-1:0] LAST_S   = TW'(2 * HALF_SLOW - 1);

  logic [TW-1:0] hi_len;
  logic [TW-1:0] last_cnt;

  always_comb begin
    if (bit_i) hi_len = slow_i ? HI_ONE_S : HI_ONE_N;
    else       hi_len = HI_ZERO;
    last_cnt = slow_i ? LAST_S : LAST_N;
  end

  assign line_o    = active_i && (tcnt_i < hi_len);
  assign bit_end_o = (tcnt_i == last_cnt);
endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq
  import led_enc_pkg::*;
#(
  parameter int unsigned RL_W = 16,
  parameter int unsigned TW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            full_i,
  input  pend_t           ent_i,
  input  logic            bit_end_i,
  input  logic [RL_W-1:0] rst_len_i,
  output logic            pop_o,
  output logic            active_o,
  output logic            idle_o,
  output logic            cur_bit_o,
  output logic            slow_o,
  output logic [TW-1:0]   tcnt_o
);
  enc_state_e      state_q;
  logic [7:0]      shreg_q;
  logic [2:0]      bit_q;
  logic            last_q;
  logic            slow_q;
  logic [TW-1:0]   tcnt_q;
  logic [RL_W-1:0] gcnt_q;
  logic [RL_W-1:0] glen_q;
  logic            byte_done;

  assign byte_done = (state_q == ST_SHIFT) && bit_end_i && (bit_q == 3'd0);

  // next byte chains straight on when the buffer is already full
  assign pop_o = tick_i && full_i &&
                 ((state_q == ST_IDLE) || (byte_done && !last_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      bit_q   <= '0;
      last_q  <= 1'b0;
      slow_q  <= 1'b0;
      tcnt_q  <= '0;
      gcnt_q  <= '0;
      glen_q  <= '0;
    end else begin
      if (tick_i) begin
        unique case (state_q)
          ST_SHIFT: begin
            if (bit_end_i) begin
              tcnt_q <= '0;
              if (bit_q == 3'd0) begin
                if (last_q) begin
                  state_q <= ST_GAP;
                  gcnt_q  <= '0;
                  glen_q  <= (rst_len_i == '0) ? RL_W'(1) : rst_len_i;
                end else if (!full_i) begin
                  state_q <= ST_IDLE;
                end
              end else begin
                bit_q <= bit_q - 3'd1;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_GAP: begin
            if (gcnt_q == glen_q - RL_W'(1)) state_q <= ST_IDLE;
            else                             gcnt_q  <= gcnt_q + 1'b1;
          end
          default: ;
        endcase
      end
      if (pop_o) begin
        state_q <= ST_SHIFT;
        shreg_q <= ent_i.data;
        last_q  <= ent_i.last;
        slow_q  <= ent_i.slow;
        bit_q   <= 3'd7;
        tcnt_q  <= '0;
      end
    end
  end

  assign active_o  = (state_q == ST_SHIFT);
  assign idle_o    = (state_q == ST_IDLE);
  assign cur_bit_o = shreg_q[bit_q];
  assign slow_o    = slow_q;
  assign tcnt_o    = tcnt_q;
endmodule

// File: rtl/led_wave_enc.sv
module led_wave_enc
  import led_enc_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 16,
  parameter int unsigned HALF_NORM = 5,
  parameter int unsigned HALF_SLOW = 6,
  parameter int unsigned ZERO_HIGH = 3,
  parameter int unsigned ONE_EXTRA = 1,
  parameter int unsigned RL_W      = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            slow_i,
  input  logic [RL_W-1:0] rst_len_i,
  input  logic [7:0]      data_i,
  input  logic            last_i,
  input  logic            valid_i,
  output logic            ready_o,
  output logic            line_o,
  output logic            busy_o
);
  localparam int unsigned TW = $clog2(2 * HALF_SLOW);

  logic          tick_w;
  logic          full_w;
  logic          pop_w;
  pend_t         in_w;
  pend_t         ent_w;
  logic          active_w;
  logic          idle_w;
  logic          cur_bit_w;
  logic          slow_w;
  logic          bit_end_w;
  logic [TW-1:0] tcnt_w;

  assign in_w = '{data: data_i, last: last_i, slow: slow_i};

  led_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_w)
  );

  led_byte_buf u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ent_i   (in_w),
    .pop_i   (pop_w),
    .ready_o (ready_o),
    .full_o  (full_w),
    .ent_o   (ent_w)
  );

  led_frame_seq #(.RL_W(RL_W), .TW(TW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .full_i    (full_w),
    .ent_i     (ent_w),
    .bit_end_i (bit_end_w),
    .rst_len_i (rst_len_i),
    .pop_o     (pop_w),
    .active_o  (active_w),
    .idle_o    (idle_w),
    .cur_bit_o (cur_bit_w),
    .slow_o    (slow_w),
    .tcnt_o    (tcnt_w)
  );

  led_bit_shaper #(
    .HALF_NORM (HALF_NORM),
    .HALF_SLOW (HALF_SLOW),
    .ZERO_HIGH (ZERO_HIGH),
    .ONE_EXTRA (ONE_EXTRA),
    .TW        (TW)
  ) u_shape (
    .active_i  (active_w),
    .bit_i     (cur_bit_w),
    .slow_i    (slow_w),
    .tcnt_i    (tcnt_w),
    .line_o    (line_o),
    .bit_end_o (bit_end_w)
  );

  assign busy_o = !idle_w || full_w;
endmodule

// File: rtl/led_wave_enc_chk.sv
module led_wave_enc_chk #(
  parameter int unsigned TICK_DIV  = 16,
  parameter int unsigned HALF_SLOW = 6,
  parameter int unsigned ONE_EXTRA = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic line_o,
  input logic busy_o,
  input logic tick_i
);
  localparam int unsigned MAXH = (HALF_SLOW + ONE_EXTRA) * TICK_DIV;
  localparam int unsigned HW   = $clog2(MAXH + 2);

  logic [HW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt_q <= '0;
    else if (line_o) hi_cnt_q <= hi_cnt_q + 1'b1;
    else             hi_cnt_q <= '0;
  end

  assert_edge_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> $past(tick_i));

  assert_pulse_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |-> (hi_cnt_q < HW'(MAXH)));

  assert_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !line_o);

  assert_busy_with_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> busy_o);

  assert_accept_fills_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);
endmodule

bind led_wave_enc led_wave_enc_chk #(
  .TICK_DIV  (TICK_DIV),
  .HALF_SLOW (HALF_SLOW),
  .ONE_EXTRA (ONE_EXTRA)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .line_o  (line_o),
  .busy_o  (busy_o),
  .tick_i  (tick_w)
);

// File: tb/tb_led_wave_enc.sv
`timescale 1ns/1ps
module tb_led_wave_enc;
  localparam int DIV = 2;
  localparam int HN  = 5;
  localparam int HS  = 6;
  localparam int ZH  = 3;
  localparam int EX  = 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slow_i = 1'b0;
  logic [15:0] rst_len_i = 16'd6;
  logic [7:0]  data_i = '0;
  logic        last_i = 1'b0;
  logic        valid_i = 1'b0;
  logic        ready_o, line_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  led_wave_enc #(.TICK_DIV(DIV), .HALF_NORM(HN), .HALF_SLOW(HS),
                 .ZERO_HIGH(ZH), .ONE_EXTRA(EX), .RL_W(16)) dut (
    .clk_i, .rst_ni, .slow_i, .rst_len_i, .data_i, .last_i, .valid_i,
    .ready_o, .line_o, .busy_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference
  logic [9:0] m_q[$];
  int   m_div, m_phase, m_tc, m_bit, m_gc, m_gl;
  logic [7:0] m_sh;
  logic m_last, m_slow;

  function automatic void load_next();
    logic [9:0] e;
    e = m_q.pop_front();
    m_sh = e[9:2]; m_last = e[1]; m_slow = e[0];
    m_bit = 7; m_tc = 0; m_phase = 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q.delete();
      m_div = 0; m_phase = 0; m_tc = 0; m_bit = 0; m_gc = 0; m_gl = 1;
      m_sh = '0; m_last = 0; m_slow = 0;
    end else begin
      bit tick, full_pre;
      int half;
      cyc++;
      tick = (m_div == DIV - 1);
      m_div = tick ? 0 : m_div + 1;
      full_pre = (m_q.size() > 0);
      if (tick) begin
        case (m_phase)
          0: if (full_pre) load_next();
          1: begin
            half = m_slow ? HS : HN;
            if (m_tc == 2 * half - 1) begin
              m_tc = 0;
              if (m_bit == 0) begin
                if (m_last) begin
                  m_phase = 2; m_gc = 0;
                  m_gl = (rst_len_i == 0) ? 1 : int'(rst_len_i);
                end else if (full_pre) load_next();
                else m_phase = 0;
              end else m_bit--;
            end else m_tc++;
          end
          default: if (m_gc == m_gl - 1) m_phase = 0; else m_gc++;
        endcase
      end
      if (valid_i && !full_pre) m_q.push_back({data_i, last_i, slow_i});
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      int hi;
      bit bv, el, eb, er;
      string tg;
      bv = m_sh[m_bit[2:0]];
      hi = bv ? ((m_slow ? HS : HN) + EX) : ZH;
      el = (m_phase == 1) && (m_tc < hi);
      eb = (m_phase != 0) || (m_q.size() > 0);
      er = (m_q.size() == 0);
      if (m_phase == 1) tg = m_slow ? "R5" : (bv ? "R4" : "R3");
      else if (m_phase == 2) tg = "R9";
      else tg = "R7";
      chk(line_o == el, {tg, " line"}, line_o, el);
      chk(busy_o == eb, "R9 busy", busy_o, eb);
      chk(ready_o == er, "R10 ready", ready_o, er);
    end
  end

  // pulse monitor
  int hl[$];
  int iv[$];
  bit prev_l = 0, have_rise = 0;
  int rise_t = 0;
  int last_fall = 0;
  always @(negedge clk_i) begin
    if (line_o && !prev_l) begin
      if (have_rise) iv.push_back(cyc - rise_t);
      rise_t = cyc; have_rise = 1;
    end
    if (!line_o && prev_l) begin
      hl.push_back(cyc - rise_t);
      last_fall = cyc;
    end
    prev_l = line_o;
  end

  task automatic mon_clear();
    hl.delete(); iv.delete(); have_rise = 0;
  endtask

  task automatic send(input logic [7:0] d, input bit lst, input bit slw);
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    valid_i = 1; data_i = d; last_i = lst; slow_i = slw;
    @(negedge clk_i);
    valid_i = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic check_bytes(input logic [7:0] b0, input logic [7:0] b1, input int nb,
                             input bit slw);
    int half;
    half = slw ? HS : HN;
    chk(hl.size() == 8 * nb, "R7 pulse count", hl.size(), 8 * nb);
    for (int i = 0; i < 8 * nb && i < hl.size(); i++) begin
      logic b;
      int e;
      b = (i < 8) ? b0[7 - i] : b1[15 - i];
      e = b ? (half + EX) * DIV : ZH * DIV;
      if (slw) chk(hl[i] == e, "R5 high", hl[i], e);
      else if (i == 0) chk(hl[i] == e, "R6 first pulse", hl[i], e);
      else chk(hl[i] == e, b ? "R4 high" : "R3 high", hl[i], e);
    end
    for (int i = 0; i < iv.size(); i++) begin
      int e;
      e = 2 * half * DIV;
      if (slw) chk(iv[i] == e, "R5 period", iv[i], e);
      else if (i == 7) chk(iv[i] == e, "R8 gapless", iv[i], e);
      else chk(iv[i] == e, "R2 period", iv[i], e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(line_o == 0, "R1 line", line_o, 0);
    chk(ready_o == 1, "R1 ready", ready_o, 1);
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(busy_o == 0 && ready_o == 1, "R1 after release", busy_o, 0);

    // gapless pair, normal rate
    mon_clear();
    rst_len_i = 16'd6;
    send(8'h80, 0, 0);
    send(8'h5A, 1, 0);
    wait_idle();
    check_bytes(8'h80, 8'h5A, 2, 0);

    // slow rate
    mon_clear();
    send(8'hC0, 1, 1);
    wait_idle();
    check_bytes(8'hC0, 8'h00, 1, 1);

    // bytes separated by idle time, zero interval length
    mon_clear();
    rst_len_i = 16'd0;
    send(8'h01, 0, 0);
    wait_idle();
    repeat (30) @(negedge clk_i);
    chk(line_o == 0, "R7 idle line", line_o, 0);
    send(8'hFE, 1, 0);
    wait_idle();
    chk(hl.size() == 16, "R7 pulse count", hl.size(), 16);

    // long latch interval
    mon_clear();
    rst_len_i = 16'd40;
    send(8'h33, 1, 0);
    wait_idle();
    chk(cyc - last_fall >= 40 * DIV, "R9 interval", cyc - last_fall, 40 * DIV);

    repeat (5) @(negedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule